// File: doc/BRIEF.md
# Block-Transfer Mailbox Host Register Port

This block is the host-facing side of a block-transfer management mailbox. A host processor reaches it through a byte-wide parallel register bus with a two-bit address. There are three live locations: a control/status register, a data port and an interrupt mask register. Through the data port the host fills an inbound request buffer and drains an outbound response buffer. The control register does its work through write-one actions. Single bits rewind the inbound count or the outbound read position, clear attention flags, toggle a host-busy flag, or announce that a request is ready.

On the other side sits a message handler. It reads the inbound buffer through a random-access port and receives a one-cycle request pulse. It deposits a response through a write port and then commits that response with its length. The commit clears the controller-busy flag and raises the response attention flag. The handler can also raise a separate system-software attention flag. Interrupt generation and message interpretation belong to neighbouring blocks. The mask register is held here and exported to them as a plain byte.

Top module: `btmb_host_port`

## Requirements
- R1: Register select uses the two address bits: 0 is control, 1 is data, 2 is mask. A read at offset 3 returns 0xFF, and a write at offset 3 changes no state.
- R2: A control read returns controller-busy in bit 7, host-busy in bit 6, system-software attention in bit 4 and response attention in bit 3. Bits 5, 2, 1 and 0 read as 0.
- R3: A data-port write stores the byte at index equal to the inbound count, but only while the count is below DEPTH. The count increments on every data write and saturates at 2*DEPTH-1. The handler reads any stored byte by index.
- R4: A control write with bit 0 set zeroes the inbound count. A control write with bit 1 set zeroes the outbound read position.
- R5: A control write with bit 3 set clears response attention, and one with bit 4 set clears system-software attention. Writing 0 to those bits leaves the flags unchanged.
- R6: A control write with bit 6 set inverts host-busy.
- R7: A control write with bit 2 set sets controller-busy. On the next cycle it drives `reqPulse` high for exactly one cycle.
- R8: A data-port read returns the outbound byte at the read position and advances the position while the position is below the outbound length. Reading the last byte returns both position and length to zero. With nothing pending, a data read returns 0xFF.
- R9: A handler commit loads the outbound length, rewinds the read position, clears controller-busy and sets response attention. `smsSet` sets system-software attention.
- R10: A mask write stores the byte. It reads back at offset 2 and drives `maskValue`.
- R11: After reset, the control flags, the inbound count, the outbound position, the outbound length and the mask are all zero, and `reqPulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access valid this cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 2 | Register offset |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (combinational) |
| reqPulse | output | 1 | One-cycle request-ready event to the handler |
| inRdIdx | input | AW | Handler inbound read index |
| inRdByte | output | 8 | Inbound byte at `inRdIdx` |
| inCount | output | AW+1 | Inbound byte count |
| outWrEn | input | 1 | Handler outbound write enable |
| outWrIdx | input | AW | Handler outbound write index |
| outWrByte | input | 8 | Handler outbound byte |
| commit | input | 1 | Publish the outbound response |
| commitLen | input | AW+1 | Response length, clamped to DEPTH |
| smsSet | input | 1 | Raise system-software attention |
| b2hAtn | output | 1 | Response attention flag |
| smsAtn | output | 1 | System-software attention flag |
| maskValue | output | 8 | Mask register contents |

## Verification
The hardest state to reach from the ports is an inbound overflow. Reaching it needs more data writes than the buffer holds, followed by a check that the excess bytes landed nowhere. The stimulus streams DEPTH+2 indexed bytes and reads the first and last slots back through the handler port. It then pushes the count into saturation. A second awkward case is a read-position rewind in the middle of a response. The bench drains part of a committed response, rewinds, and drains the whole response again up to the 0xFF empty marker.

// File: rtl/btmb_pkg.sv
package btmb_pkg;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;

  localparam int B_CLR_WR = 0;
  localparam int B_CLR_RD = 1;
  localparam int B_REQ    = 2;
  localparam int B_RSPATN = 3;
  localparam int B_SMSATN = 4;
  localparam int B_HBUSY  = 6;
  localparam int B_CBUSY  = 7;

  typedef struct packed {
    logic clrWrPtr;
    logic clrRdPtr;
    logic dataWr;
    logic dataRd;
  } dp_strobe_t;
endpackage

// File: rtl/btmb_ctrl.sv
module btmb_ctrl
  import btmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWdata,
  input  logic [7:0] outDataByte,
  input  logic       commit,
  input  logic       smsSet,
  output dp_strobe_t strobes,
  output logic [7:0] hostRdata,
  output logic       reqPulse,
  output logic       b2hAtn,
  output logic       smsAtn,
  output logic [7:0] maskValue
);
  logic hostBusyQ, ctlBusyQ, rspAtnQ, smsAtnQ, reqQ;
  logic [7:0] maskQ;
  logic ctrlWr, maskWr, reqWr;

  assign ctrlWr = hostSel && hostWr && (hostAddr == OFS_CTRL);
  assign maskWr = hostSel && hostWr && (hostAddr == OFS_MASK);
  assign reqWr  = ctrlWr && hostWdata[B_REQ];

  always_comb begin
    strobes.clrWrPtr = ctrlWr && hostWdata[B_CLR_WR];
    strobes.clrRdPtr = ctrlWr && hostWdata[B_CLR_RD];
    strobes.dataWr   = hostSel && hostWr && (hostAddr == OFS_DATA);
    strobes.dataRd   = hostSel && !hostWr && (hostAddr == OFS_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hostBusyQ <= 1'b0;
      ctlBusyQ  <= 1'b0;
      rspAtnQ   <= 1'b0;
      smsAtnQ   <= 1'b0;
      reqQ      <= 1'b0;
      maskQ     <= 8'h00;
    end else begin
      reqQ <= reqWr;
      if (ctrlWr && hostWdata[B_HBUSY]) hostBusyQ <= !hostBusyQ;
      if (reqWr)       ctlBusyQ <= 1'b1;
      else if (commit) ctlBusyQ <= 1'b0;
      if (commit)                                rspAtnQ <= 1'b1;
      else if (ctrlWr && hostWdata[B_RSPATN])    rspAtnQ <= 1'b0;
      if (smsSet)                                smsAtnQ <= 1'b1;
      else if (ctrlWr && hostWdata[B_SMSATN])    smsAtnQ <= 1'b0;
      if (maskWr) maskQ <= hostWdata;
    end
  end

  always_comb begin
    unique case (hostAddr)
      OFS_CTRL: hostRdata = {ctlBusyQ, hostBusyQ, 1'b0, smsAtnQ, rspAtnQ, 3'b000};
      OFS_DATA: hostRdata = outDataByte;
      OFS_MASK: hostRdata = maskQ;
      default:  hostRdata = 8'hFF;
    endcase
  end

  assign reqPulse  = reqQ;
  assign b2hAtn    = rspAtnQ;
  assign smsAtn    = smsAtnQ;
  assign maskValue = maskQ;

  assert_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reqWr |=> (ctlBusyQ && reqPulse));
  assert_req_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reqPulse |-> $past(ctrlWr && hostWdata[B_REQ]));
  assert_hbusy_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWr && hostWdata[B_HBUSY]) |=> (hostBusyQ != $past(hostBusyQ)));
  assert_commit_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !reqWr) |=> (rspAtnQ && !ctlBusyQ));
endmodule

// File: rtl/btmb_datapath.sv
module btmb_datapath
  import btmb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dp_strobe_t    strobes,
  input  logic [7:0]    hostWdata,
  input  logic [AW-1:0] inRdIdx,
  output logic [7:0]    inRdByte,
  output logic [CW-1:0] inCount,
  input  logic          outWrEn,
  input  logic [AW-1:0] outWrIdx,
  input  logic [7:0]    outWrByte,
  input  logic          commit,
  input  logic [CW-1:0] commitLen,
  output logic [7:0]    outDataByte
);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);
  localparam logic [CW-1:0] CMAX = '1;

  logic [7:0]    inBuf  [DEPTH];
  logic [7:0]    outBuf [DEPTH];
  logic [CW-1:0] inCnt, outPos, outLen;
  logic          outAvail;

  assign outAvail = outPos < outLen;

  always_ff @(posedge clk) begin
    if (strobes.dataWr && inCnt < CAP) inBuf[inCnt[AW-1:0]] <= hostWdata;
    if (outWrEn) outBuf[outWrIdx] <= outWrByte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inCnt  <= '0;
      outPos <= '0;
      outLen <= '0;
    end else begin
      if (strobes.clrWrPtr)                     inCnt <= '0;
      else if (strobes.dataWr && inCnt != CMAX) inCnt <= inCnt + 1'b1;

      if (commit) begin
        outPos <= '0;
        outLen <= (commitLen > CAP) ? CAP : commitLen;
      end else if (strobes.clrRdPtr) begin
        outPos <= '0;
      end else if (strobes.dataRd && outAvail) begin
        if (outPos + 1'b1 == outLen) begin
          outPos <= '0;
          outLen <= '0;
        end else begin
          outPos <= outPos + 1'b1;
        end
      end
    end
  end

  assign inRdByte    = inBuf[inRdIdx];
  assign inCount     = inCnt;
  assign outDataByte = outAvail ? outBuf[outPos[AW-1:0]] : 8'hFF;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.dataWr && !strobes.clrWrPtr && inCnt != CMAX) |=> (inCnt == CW'($past(inCnt) + 1)));
  assert_pos_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outPos <= outLen);
  assert_drain_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.dataRd && !strobes.clrRdPtr && !commit && outLen != '0 && outPos + 1'b1 == outLen)
      |=> (outLen == '0 && outPos == '0));
  assert_clr_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clrRdPtr && !commit) |=> (outPos == '0));
endmodule

// File: rtl/btmb_host_port.sv
module btmb_host_port
  import btmb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hostSel,
  input  logic          hostWr,
  input  logic [1:0]    hostAddr,
  input  logic [7:0]    hostWdata,
  output logic [7:0]    hostRdata,
  output logic          reqPulse,
  input  logic [AW-1:0] inRdIdx,
  output logic [7:0]    inRdByte,
  output logic [CW-1:0] inCount,
  input  logic          outWrEn,
  input  logic [AW-1:0] outWrIdx,
  input  logic [7:0]    outWrByte,
  input  logic          commit,
  input  logic [CW-1:0] commitLen,
  input  logic          smsSet,
  output logic          b2hAtn,
  output logic          smsAtn,
  output logic [7:0]    maskValue
);
  dp_strobe_t strobes;
  logic [7:0] outDataByte;

  btmb_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .outDataByte(outDataByte), .commit(commit), .smsSet(smsSet),
    .strobes(strobes), .hostRdata(hostRdata), .reqPulse(reqPulse),
    .b2hAtn(b2hAtn), .smsAtn(smsAtn), .maskValue(maskValue)
  );

  btmb_datapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .hostWdata(hostWdata),
    .inRdIdx(inRdIdx), .inRdByte(inRdByte), .inCount(inCount),
    .outWrEn(outWrEn), .outWrIdx(outWrIdx), .outWrByte(outWrByte),
    .commit(commit), .commitLen(commitLen), .outDataByte(outDataByte)
  );
endmodule

// File: tb/tb_btmb_host_port.sv
`timescale 1ns/100ps
module tb_btmb_host_port;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0;
  logic [1:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic reqPulse;
  logic [AW-1:0] inRdIdx = '0;
  logic [7:0] inRdByte;
  logic [CW-1:0] inCount;
  logic outWrEn = 1'b0;
  logic [AW-1:0] outWrIdx = '0;
  logic [7:0] outWrByte = '0;
  logic commit = 1'b0;
  logic [CW-1:0] commitLen = '0;
  logic smsSet = 1'b0;
  logic b2hAtn, smsAtn;
  logic [7:0] maskValue;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  btmb_host_port #(.DEPTH(DEPTH)) dut (.*);

  typedef struct packed {
    logic       isWr;
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd11}, // R11 control clear after reset
    '{1'b0, 2'd1, 8'h00, 8'hFF, 4'd8},  // R8 empty data read
    '{1'b0, 2'd3, 8'h00, 8'hFF, 4'd1},  // R1 offset 3 reads FF
    '{1'b1, 2'd2, 8'h5A, 8'h00, 4'd10},
    '{1'b0, 2'd2, 8'h00, 8'h5A, 4'd10}, // R10 mask readback
    '{1'b1, 2'd3, 8'h00, 8'h00, 4'd1},
    '{1'b0, 2'd2, 8'h00, 8'h5A, 4'd1},  // R1 offset 3 write ignored
    '{1'b1, 2'd0, 8'h40, 8'h00, 4'd6},
    '{1'b0, 2'd0, 8'h00, 8'h40, 4'd6},  // R6 host busy on
    '{1'b1, 2'd0, 8'h40, 8'h00, 4'd6},
    '{1'b0, 2'd0, 8'h00, 8'h00, 4'd6},  // R6 host busy off
    '{1'b1, 2'd0, 8'h04, 8'h00, 4'd7},
    '{1'b0, 2'd0, 8'h00, 8'h80, 4'd7},  // R7 controller busy, R2 bit 7
    '{1'b1, 2'd0, 8'h18, 8'h00, 4'd5},
    '{1'b0, 2'd0, 8'h00, 8'h80, 4'd5}   // R5 busy untouched by flag clears
  };

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk); #1;
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    @(posedge clk); #1;
    hostSel = 1'b0;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      finish();
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R11 inCount", int'(inCount), 0);
    check("R11 reqPulse", int'(reqPulse), 0);
    check("R11 maskValue", int'(maskValue), 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isWr) hostWrite(VECS[i].addr, VECS[i].data);
      else begin
        hostRead(VECS[i].addr, rd);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), int'(rd), int'(VECS[i].exp));
      end
    end

    // R7 pulse timing
    hostWrite(2'd0, 8'h04);
    check("R7 pulse high", int'(reqPulse), 1);
    @(posedge clk); #1;
    check("R7 pulse one cycle", int'(reqPulse), 0);

    // R3 inbound store and handler read
    hostWrite(2'd0, 8'h01);
    hostWrite(2'd1, 8'hA1);
    hostWrite(2'd1, 8'hA2);
    hostWrite(2'd1, 8'hA3);
    check("R3 count", int'(inCount), 3);
    inRdIdx = 1; #1;
    check("R3 byte", int'(inRdByte), 8'hA2);

    // R3 overflow: bytes past capacity land nowhere
    hostWrite(2'd0, 8'h01);
    check("R4 clear count", int'(inCount), 0);
    for (int i = 0; i < DEPTH + 2; i++) hostWrite(2'd1, 8'(i + 8'h10));
    check("R3 overflow count", int'(inCount), DEPTH + 2);
    inRdIdx = AW'(DEPTH - 1); #1;
    check("R3 last slot", int'(inRdByte), (DEPTH - 1 + 16) & 8'hFF);
    inRdIdx = 0; #1;
    check("R3 slot0 kept", int'(inRdByte), 8'h10);
    inRdIdx = 1; #1;
    check("R3 slot1 kept", int'(inRdByte), 8'h11);
    for (int i = 0; i < DEPTH; i++) hostWrite(2'd1, 8'h00);
    check("R3 saturate", int'(inCount), 2 * DEPTH - 1);

    // R9 handler commit
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      outWrEn = 1'b1; outWrIdx = AW'(i); outWrByte = 8'(8'hB0 + i);
      @(negedge clk);
    end
    outWrEn = 1'b0; commit = 1'b1; commitLen = CW'(3);
    @(negedge clk); commit = 1'b0;
    check("R9 b2hAtn", int'(b2hAtn), 1);
    hostRead(2'd0, rd);
    check("R9 R2 ctrl after commit", int'(rd), 8'h08);

    // R8 drain with rewind
    hostRead(2'd1, rd); check("R8 byte0", int'(rd), 8'hB0);
    hostRead(2'd1, rd); check("R8 byte1", int'(rd), 8'hB1);
    hostWrite(2'd0, 8'h02);
    hostRead(2'd1, rd); check("R4 rewind byte0", int'(rd), 8'hB0);
    hostRead(2'd1, rd); check("R8 byte1 again", int'(rd), 8'hB1);
    hostRead(2'd1, rd); check("R8 last byte", int'(rd), 8'hB2);
    hostRead(2'd1, rd); check("R8 empty after drain", int'(rd), 8'hFF);
    hostWrite(2'd0, 8'h02);
    hostRead(2'd1, rd); check("R8 rewind after drain stays empty", int'(rd), 8'hFF);

    // R5 attention clears
    hostWrite(2'd0, 8'h00);
    check("R5 zero write keeps b2h", int'(b2hAtn), 1);
    hostWrite(2'd0, 8'h08);
    check("R5 clear b2h", int'(b2hAtn), 0);
    @(negedge clk) smsSet = 1'b1;
    @(negedge clk) smsSet = 1'b0;
    hostRead(2'd0, rd);
    check("R9 R2 sms flag", int'(rd), 8'h10);
    hostWrite(2'd0, 8'h10);
    check("R5 clear sms", int'(smsAtn), 0);
    check("R10 maskValue", int'(maskValue), 8'h5A);

    finish();
  end
endmodule